// File: doc/BRIEF.md
# Dual-Path Single-Precision Floating-Point Adder

This block adds or subtracts two IEEE-754 single-precision operands in a fixed three-stage pipeline. It takes a new operation on every clock and returns each result exactly three register stages later, in issue order. A subtract request inverts the sign of the second operand before anything else is done.

The first stage decodes both operands, flags infinities and NaNs, and orders the operands by magnitude. The middle stage holds two datapaths that work side by side. The near path takes effective subtractions whose effective exponents differ by zero or one. It subtracts, counts leading zeros and shifts left to renormalize, stopping early when the result becomes subnormal. The far path takes every other case. It right-aligns the smaller significand and keeps guard, round and sticky bits. Both path results are registered. The last stage picks the result of the path that applies, rounds to nearest-even, and encodes a subnormal, infinity or special result.

Only round-to-nearest-even is offered, and no exception flags are produced.

Top module: `fp_dual_add`

## Requirements
- R1: While rst_ni is low and after its release, before any operation has been issued, valid_o is 0 and result_o is 32'h00000000.
- R2: An operation sampled with valid_i high at a rising edge produces valid_o high with its result after the third rising edge, counting the sampling edge as the first. One operation is accepted per clock, results keep issue order, and valid_o is low in cycles with no matching issue.
- R3: result_o is the correctly rounded (round-to-nearest, ties-to-even) value of a_i + b_i when sub_i is 0, and of a_i − b_i when sub_i is 1. Subtraction is performed by inverting bit 31 of b_i.
- R4: For an effective subtraction with an effective exponent difference of 0 or 1, the result is exact and renormalized, including heavy cancellation down to the last significand bit (for example 3F800001 − 3F800000 = 34000000).
- R5: For the other cases, the smaller operand is aligned with guard, round and sticky bits. An alignment of 26 or more places leaves only a sticky bit, so 1.0 plus a value below half an ulp yields 1.0, an exact halfway tie rounds to the even neighbour, and an odd neighbour rounds up.
- R6: An exact zero sum is +0 (32'h00000000). The only exception is when both effective operands are −0, which gives −0 (32'h80000000).
- R7: Subnormal inputs (exponent field 0) are read with exponent 1 and no hidden bit. A result whose magnitude is below 2^-126 is emitted with exponent field 0. Rounding that carries a subnormal up to 2^-126 yields exponent field 1.
- R8: A finite result whose rounded magnitude reaches 2^128 is a signed infinity: 7F800000 or FF800000.
- R9: An infinity plus a finite value, or plus an infinity of the same effective sign, returns that infinity. Infinities of opposite effective sign give 7FC00000.
- R10: Any NaN input (exponent field 255, nonzero fraction, quiet or signalling, any sign) gives the canonical quiet NaN 7FC00000. No other NaN encoding ever appears on result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on a_i, b_i, sub_i |
| a_i | input | 32 | First operand, single precision |
| b_i | input | 32 | Second operand, single precision |
| sub_i | input | 1 | 1 selects a_i − b_i, 0 selects a_i + b_i |
| valid_o | output | 1 | result_o holds a new result |
| result_o | output | 32 | Rounded sum or difference |

## Verification
The pipeline carries no state from one operation to the next, so a wrong internal value spoils only the operation passing through. It appears on result_o at that operation's third edge and not later. Errors show up in recognizable ways. A wrong leading-zero count or a clamp that fails at the subnormal boundary gives a fraction that is shifted, with the exponent off by the same amount. A lost sticky bit or a wrong alignment gives a result one ulp off, mainly at halfway ties. A wrong path choice makes near-cancellation results lose bits. A broken valid stage drops a valid_o pulse or adds one, which the ordered scoreboard sees as a missing result or an unexpected one.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int EXT_W  = SIG_W + 3;      // significand + guard, round, sticky
  localparam int NEAR_W = SIG_W + 1;      // one extra bit for a one-place offset
  localparam int LZ_W   = $clog2(NEAR_W + 1);

  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(MAN_W-1){1'b0}}};

  typedef struct packed {
    logic [EXP_W:0]   exp;
    logic [EXT_W-1:0] sig;   // [EXT_W-1] is the integer bit when normal
  } path_res_t;
endpackage

// File: rtl/fpa_lzc.sv
`timescale 1ns/1ps
module fpa_lzc #(
  parameter int W  = 25,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++)
      if (val_i[i]) cnt_o = CW'(W - 1 - i);
  end
endmodule

// File: rtl/fpa_near_path.sv
`timescale 1ns/1ps
module fpa_near_path
  import fpa_pkg::*;
(
  input  logic [EXP_W-1:0] ex_i,
  input  logic [SIG_W-1:0] sigx_i,
  input  logic [SIG_W-1:0] sigy_i,
  input  logic             dist_one_i,
  output path_res_t        res_o,
  output logic             zero_o
);
  logic [NEAR_W-1:0] diff, norm;
  logic [LZ_W-1:0]   lz;
  logic [EXP_W-1:0]  room, shamt;

  // operands are magnitude-ordered, so the difference never goes negative
  always_comb
    diff = {sigx_i, 1'b0} - (dist_one_i ? {1'b0, sigy_i} : {sigy_i, 1'b0});

  fpa_lzc #(.W(NEAR_W), .CW(LZ_W)) u_lzc (
    .val_i (diff),
    .cnt_o (lz)
  );

  always_comb begin
    room   = ex_i - EXP_W'(1);
    // clamp at the subnormal boundary
    shamt  = (EXP_W'(lz) > room) ? room : EXP_W'(lz);
    norm   = diff << shamt;
    res_o.sig = {norm, 2'b00};
    res_o.exp = {1'b0, ex_i - shamt};
    zero_o    = (diff == '0);
  end
endmodule

// File: rtl/fpa_far_path.sv
`timescale 1ns/1ps
module fpa_far_path
  import fpa_pkg::*;
(
  input  logic [EXP_W-1:0] ex_i,
  input  logic [SIG_W-1:0] sigx_i,
  input  logic [SIG_W-1:0] sigy_i,
  input  logic [EXP_W-1:0] dist_i,
  input  logic             eff_sub_i,
  output path_res_t        res_o
);
  localparam int ALIGN_W = SIG_W + 2;

  logic [EXT_W-1:0]     x_ext, y_ext;
  logic [2*ALIGN_W-1:0] wide;
  logic [EXT_W:0]       sum;

  always_comb begin
    x_ext = {sigx_i, 3'b000};
    wide  = {sigy_i, 2'b00, {ALIGN_W{1'b0}}} >> dist_i;
    if (dist_i >= EXP_W'(ALIGN_W))
      y_ext = {{(EXT_W-1){1'b0}}, |sigy_i};
    else
      y_ext = {wide[2*ALIGN_W-1:ALIGN_W], |wide[ALIGN_W-1:0]};

    sum = eff_sub_i ? ({1'b0, x_ext} - {1'b0, y_ext})
                    : ({1'b0, x_ext} + {1'b0, y_ext});

    if (sum[EXT_W]) begin
      res_o.sig = {sum[EXT_W:2], |sum[1:0]};
      res_o.exp = {1'b0, ex_i} + (EXP_W+1)'(1);
    end else if (sum[EXT_W-1] || !eff_sub_i) begin
      // unnormalized only for a subnormal sum at exponent 1
      res_o.sig = sum[EXT_W-1:0];
      res_o.exp = {1'b0, ex_i};
    end else begin
      res_o.sig = {sum[EXT_W-2:0], 1'b0};
      res_o.exp = {1'b0, ex_i} - (EXP_W+1)'(1);
    end
  end
endmodule

// File: rtl/fpa_round.sv
`timescale 1ns/1ps
module fpa_round
  import fpa_pkg::*;
(
  input  path_res_t         res_i,
  output logic [WORD_W-2:0] mag_o
);
  logic [EXP_W-1:0]  efield;
  logic [MAN_W-1:0]  frac;
  logic              guard, sticky, up;
  logic [WORD_W-2:0] rounded;

  always_comb begin
    efield  = res_i.sig[EXT_W-1] ? res_i.exp[EXP_W-1:0] : '0;
    frac    = res_i.sig[EXT_W-2:3];
    guard   = res_i.sig[2];
    sticky  = |res_i.sig[1:0];
    up      = guard & (sticky | res_i.sig[3]);
    // carry out of the fraction bumps the exponent field, up to infinity
    rounded = {efield, frac} + (WORD_W-1)'(up);
    if (res_i.exp >= {1'b0, EXP_MAX})
      mag_o = {EXP_MAX, {MAN_W{1'b0}}};
    else
      mag_o = rounded;
  end
endmodule

// File: rtl/fp_dual_add.sv
`timescale 1ns/1ps
module fp_dual_add
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o
);
  // ---------------- stage 0: decode, classify, order ----------------
  logic              b_sgn, eff_sub, swap, big_sgn;
  logic              a_nan, b_nan, a_inf, b_inf, spec;
  logic [WORD_W-2:0] big_mag, small_mag;
  logic [EXP_W-1:0]  big_ee, small_ee;
  logic [WORD_W-1:0] spec_val;

  always_comb begin
    b_sgn     = b_i[WORD_W-1] ^ sub_i;
    eff_sub   = a_i[WORD_W-1] ^ b_sgn;
    swap      = b_i[WORD_W-2:0] > a_i[WORD_W-2:0];
    big_mag   = swap ? b_i[WORD_W-2:0] : a_i[WORD_W-2:0];
    small_mag = swap ? a_i[WORD_W-2:0] : b_i[WORD_W-2:0];
    big_sgn   = swap ? b_sgn : a_i[WORD_W-1];
    big_ee    = (big_mag[WORD_W-2:MAN_W] == '0)   ? EXP_W'(1) : big_mag[WORD_W-2:MAN_W];
    small_ee  = (small_mag[WORD_W-2:MAN_W] == '0) ? EXP_W'(1) : small_mag[WORD_W-2:MAN_W];

    a_nan = (a_i[WORD_W-2:MAN_W] == EXP_MAX) && (a_i[MAN_W-1:0] != '0);
    b_nan = (b_i[WORD_W-2:MAN_W] == EXP_MAX) && (b_i[MAN_W-1:0] != '0);
    a_inf = (a_i[WORD_W-2:MAN_W] == EXP_MAX) && (a_i[MAN_W-1:0] == '0);
    b_inf = (b_i[WORD_W-2:MAN_W] == EXP_MAX) && (b_i[MAN_W-1:0] == '0);
    spec  = a_nan | b_nan | a_inf | b_inf;

    if (a_nan | b_nan | (a_inf & b_inf & eff_sub)) spec_val = QNAN;
    else if (a_inf) spec_val = {a_i[WORD_W-1], EXP_MAX, {MAN_W{1'b0}}};
    else            spec_val = {b_sgn, EXP_MAX, {MAN_W{1'b0}}};
  end

  logic              s1_valid, s1_spec, s1_sgn, s1_eff_sub;
  logic [WORD_W-1:0] s1_spec_val;
  logic [EXP_W-1:0]  s1_ex, s1_dist;
  logic [SIG_W-1:0]  s1_sigx, s1_sigy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid    <= 1'b0;
      s1_spec     <= 1'b0;
      s1_spec_val <= '0;
      s1_sgn      <= 1'b0;
      s1_eff_sub  <= 1'b0;
      s1_ex       <= '0;
      s1_dist     <= '0;
      s1_sigx     <= '0;
      s1_sigy     <= '0;
    end else begin
      s1_valid    <= valid_i;
      s1_spec     <= spec;
      s1_spec_val <= spec_val;
      s1_sgn      <= big_sgn;
      s1_eff_sub  <= eff_sub;
      s1_ex       <= big_ee;
      s1_dist     <= big_ee - small_ee;
      s1_sigx     <= {|big_mag[WORD_W-2:MAN_W], big_mag[MAN_W-1:0]};
      s1_sigy     <= {|small_mag[WORD_W-2:MAN_W], small_mag[MAN_W-1:0]};
    end
  end

  // ---------------- stage 1: near and far paths in parallel ----------------
  logic      near_sel, near_zero;
  path_res_t near_res, far_res;

  always_comb near_sel = s1_eff_sub && (s1_dist < EXP_W'(2));

  fpa_near_path u_near (
    .ex_i       (s1_ex),
    .sigx_i     (s1_sigx),
    .sigy_i     (s1_sigy),
    .dist_one_i (s1_dist[0]),
    .res_o      (near_res),
    .zero_o     (near_zero)
  );

  fpa_far_path u_far (
    .ex_i      (s1_ex),
    .sigx_i    (s1_sigx),
    .sigy_i    (s1_sigy),
    .dist_i    (s1_dist),
    .eff_sub_i (s1_eff_sub),
    .res_o     (far_res)
  );

  logic              s2_valid, s2_spec, s2_sgn, s2_near_sel, s2_near_zero;
  logic [WORD_W-1:0] s2_spec_val;
  path_res_t         s2_near, s2_far;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid     <= 1'b0;
      s2_spec      <= 1'b0;
      s2_spec_val  <= '0;
      s2_sgn       <= 1'b0;
      s2_near_sel  <= 1'b0;
      s2_near_zero <= 1'b0;
      s2_near      <= '0;
      s2_far       <= '0;
    end else begin
      s2_valid     <= s1_valid;
      s2_spec      <= s1_spec;
      s2_spec_val  <= s1_spec_val;
      s2_sgn       <= s1_sgn;
      s2_near_sel  <= near_sel;
      s2_near_zero <= near_zero;
      s2_near      <= near_res;
      s2_far       <= far_res;
    end
  end

  // R4
  near_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_valid && !s2_spec && s2_near_sel && !s2_near_zero && (s2_near.exp > (EXP_W+1)'(1))
      |-> s2_near.sig[EXT_W-1]);

  // R5
  far_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_valid && !s2_spec && !s2_near_sel && (s2_far.exp > (EXP_W+1)'(1))
      |-> s2_far.sig[EXT_W-1]);

  // ---------------- stage 2: select, round, encode ----------------
  path_res_t         pick;
  logic [WORD_W-2:0] mag;
  logic              res_sgn;
  logic [WORD_W-1:0] result_d;

  always_comb pick = s2_near_sel ? s2_near : s2_far;

  fpa_round u_round (
    .res_i (pick),
    .mag_o (mag)
  );

  always_comb begin
    res_sgn  = s2_sgn & ~(s2_near_sel & s2_near_zero);
    result_d = s2_spec ? s2_spec_val : {res_sgn, mag};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s2_valid;
      if (s2_valid) result_o <= result_d;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3));

  // R6
  cancel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_valid && !s2_spec && s2_near_sel && s2_near_zero |=> valid_o && (result_o == '0));

  // R10
  canon_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (result_o[WORD_W-2:MAN_W] == EXP_MAX) && (result_o[MAN_W-1:0] != '0)
      |-> result_o == QNAN);
endmodule

// File: tb/fp_dual_add_bench.sv
`timescale 1ns/1ps
module fp_dual_add_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        sub_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;

  fp_dual_add u_fp_dual_add (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (sub_i),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t q[$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  localparam logic [31:0] QNAN = 32'h7FC00000;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // ---- reference model, built on double arithmetic ----
  function automatic real f2r(logic [31:0] f);
    int          ee;
    logic [23:0] sig;
    logic [10:0] be;
    real         v;
    ee  = (f[30:23] == 8'h00) ? 1 : int'(f[30:23]);
    sig = {|f[30:23], f[22:0]};
    be  = 11'(ee - 150 + 1023);
    v   = real'(sig) * $bitstoreal({1'b0, be, 52'b0});
    return f[31] ? -v : v;
  endfunction

  function automatic logic [31:0] r2f(real r);
    logic [63:0] d, sig, qv, rem, half;
    int          e, sh;
    d = $realtobits(r);
    if (d[62:0] == '0) return {d[63], 31'b0};
    e   = int'(d[62:52]) - 1023;
    sig = {11'b0, 1'b1, d[51:0]};
    if (e >= -126) begin
      qv   = sig >> 29;
      rem  = sig & 64'h1FFF_FFFF;
      half = 64'h1000_0000;
      if (rem > half || (rem == half && qv[0])) qv = qv + 1;
      if (qv[24]) begin qv = qv >> 1; e = e + 1; end
      if (e > 127) return {d[63], 8'hFF, 23'b0};
      return {d[63], 8'(e + 127), qv[22:0]};
    end
    sh = -97 - e;
    if (sh >= 64) return {d[63], 31'b0};
    qv   = sig >> sh;
    rem  = sig & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && qv[0])) qv = qv + 1;
    return {d[63], qv[30:0]};
  endfunction

  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, logic s);
    logic [31:0] bb;
    logic        an, bn, ai, bi;
    real         r;
    bb = {b[31] ^ s, b[30:0]};
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (an || bn) return QNAN;
    if (ai && bi) return (a[31] != bb[31]) ? QNAN : a;
    if (ai) return a;
    if (bi) return bb;
    if (a[30:0] == 0 && bb[30:0] == 0) return {a[31] & bb[31], 31'b0};
    r = f2r(a) + f2r(bb);
    if (r == 0.0) return 32'h0;
    return r2f(r);
  endfunction

  // ---- driver ----
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; sub_i = s; valid_i = 1'b1;
    it.exp = ref_add(a, b, s);
    it.due = cyc + 3;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // ---- monitor ----
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected valid_o", result_o, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        if (cyc != it.due)
          check(1'b0, "R2 latency", 32'(cyc), 32'(it.due));
        else
          check(result_o == it.exp, it.tag, result_o, it.exp);
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(valid_o == 1'b0 && result_o == 32'h0, "R1 in reset", result_o, 32'h0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release, nothing issued
    check(valid_o == 1'b0 && result_o == 32'h0, "R1 idle", {31'b0, valid_o}, 32'h0);

    // R3 basic add/sub
    send(32'h3F800000, 32'h40000000, 1'b0, "R3 1+2");
    send(32'h40400000, 32'h3F800000, 1'b1, "R3 3-1");
    send(32'h3FC00000, 32'hC0100000, 1'b1, "R3 1.5-(-2.25)");
    send(32'hC1200000, 32'h40A00000, 1'b0, "R3 -10+5");
    // R4 near path cancellation
    send(32'h3F800001, 32'h3F800000, 1'b1, "R4 tiny diff d0");
    send(32'h40000000, 32'h3FFFFFFF, 1'b1, "R4 d1 cancel");
    send(32'h3F800000, 32'hBF7FFFFF, 1'b0, "R4 d1 add-neg");
    send(32'h4B7FFFFF, 32'h4B7FFFFE, 1'b1, "R4 large d0");
    // R5 far path alignment and rounding
    send(32'h3F800000, 32'h30800000, 1'b0, "R5 sticky only");
    send(32'h3F800000, 32'h33800000, 1'b0, "R5 tie to even");
    send(32'h3F800001, 32'h33800000, 1'b0, "R5 tie round up");
    send(32'h3F800000, 32'h33800001, 1'b0, "R5 above half");
    send(32'h3F800000, 32'h33000000, 1'b1, "R5 sub d>=2");
    send(32'h3F800000, 32'h00000001, 1'b1, "R5 huge shift");
    // R6 zeros
    send(32'h3F800000, 32'h3F800000, 1'b1, "R6 x-x");
    send(32'h80000000, 32'h80000000, 1'b0, "R6 -0+-0");
    send(32'h80000000, 32'h00000000, 1'b1, "R6 -0-+0");
    send(32'h00000000, 32'h80000000, 1'b0, "R6 +0+-0");
    send(32'hC0400000, 32'h40400000, 1'b0, "R6 -3+3");
    // R7 subnormals
    send(32'h00000001, 32'h00000001, 1'b0, "R7 min+min");
    send(32'h00800000, 32'h00000001, 1'b1, "R7 norm to sub");
    send(32'h007FFFFF, 32'h00000001, 1'b0, "R7 sub to norm");
    send(32'h00C00000, 32'h00A00000, 1'b1, "R7 near to sub");
    send(32'h01000001, 32'h00FFFFFF, 1'b1, "R7 d1 sub");
    // R8 overflow
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R8 pos ovf");
    send(32'hFF7FFFFF, 32'h7F000000, 1'b1, "R8 neg ovf");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, "R8 round ovf");
    // R9 infinities
    send(32'h7F800000, 32'h3F800000, 1'b0, "R9 inf+1");
    send(32'h7F800000, 32'h7F800000, 1'b1, "R9 inf-inf");
    send(32'hFF800000, 32'h00000000, 1'b0, "R9 -inf+0");
    send(32'h3F800000, 32'h7F800000, 1'b1, "R9 1-inf");
    send(32'hFF800000, 32'hFF800000, 1'b0, "R9 -inf+-inf");
    // R10 NaNs
    send(32'h7FC00000, 32'h3F800000, 1'b0, "R10 qnan");
    send(32'h7F800001, 32'h7F800000, 1'b0, "R10 snan+inf");
    send(32'h3F800000, 32'hFFC00123, 1'b1, "R10 neg nan");
    idle();
    repeat (5) idle();

    // R2 back-to-back mixed stream, R3 random coverage
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      logic        s;
      int          m;
      a = $urandom; b = $urandom; s = 1'($urandom);
      m = int'($urandom % 5);
      case (m)
        1: begin
             b[30:23] = a[30:23] + 8'(($urandom % 3)) - 8'd1;
             b[22:0]  = a[22:0] ^ 23'($urandom % 512);
             b[31]    = a[31] ^ s ^ 1'b1;
           end
        2: begin a[30:23] = 8'($urandom % 3); b[30:23] = 8'($urandom % 3); end
        3: begin a[30:23] = 8'hFE - 8'($urandom % 2); b[30:23] = 8'hFE - 8'($urandom % 3); end
        4: b[30:23] = a[30:23] - 8'(($urandom % 30));
        default: ;
      endcase
      send(a, b, s, "R3 random");
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (8) idle();
    check(q.size() == 0, "R2 all results returned", 32'(q.size()), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule